// File: doc/BRIEF.md
# Anti-Diagonal Alignment Score Engine

This block computes the score matrix used in global sequence alignment. The matrix lives inside the block as a flat, row-major array whose row width is a parameter (`COLS`). A second array of the same size holds one reference score per cell. The host first loads both arrays through a single load/readback port. It then pulses `start`. The engine walks the matrix one anti-diagonal at a time and writes one cell per clock.

Each new cell is the largest of three candidates. The first is its upper-left neighbour plus the reference score of the cell itself. The second is its left neighbour minus the gap penalty. The third is its upper neighbour minus the same penalty. Only one writer exists for the matrix: a sequential engine that drives one shared index register. The host write path is shut off while the engine runs. When the walk ends, `done` rises and stays high until the next run is requested. The host can then read every cell back.

Top module: `nw_scorer`

## Requirements
- R1: After synchronous reset, `busy` and `done` are both 0.
- R2: Cells are addressed row-major as `row*COLS + col`, using an index of `$clog2(COLS*ROWS)` bits (7 bits by default) that is never narrowed. Step `s` of diagonal `d` writes flat cell `(s+1)*COLS + (d+1-s)`. Within one diagonal, `s` runs 0..d, so diagonal `d` holds `d+1` cells.
- R3: The written value is the maximum of three terms: `M[k-1-COLS] + REF[k]`, `M[k-1] - penalty` and `M[k-COLS] - penalty`.
- R4: Scores, reference values and the penalty are signed 16-bit. Sums and differences wrap modulo 2^16 without saturation, and the maximum compares the wrapped signed values.
- R5: Diagonals run in ascending order from 0 to `COLS-4`. Row 0, column 0 and every cell off those diagonals keep their loaded values.
- R6: The engine writes exactly one cell per clock. Take the clock edge that samples `start` while idle as edge 0. With N = (COLS-3)(COLS-2)/2 cells (15 by default), `done` becomes 1 after edge N+1 and `busy` is 1 from edge 0 until that edge.
- R7: `done` stays 1 until a `start` is sampled while idle. After that edge, `done` is 0 and `busy` is 1.
- R8: A `start` sampled while `busy` is 1 has no effect on the run, its timing or its results.
- R9: Host port: `host_sel`=0 selects the score matrix and 1 the reference array. `host_we` writes `host_wdata` at `host_addr` only while `busy` is 0; writes while busy are dropped. `host_rdata` returns the selected array at `host_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request pulse |
| penalty | input | 16 | Signed gap penalty, held steady during a run |
| host_we | input | 1 | Host write enable |
| host_sel | input | 1 | Array select: 0 score matrix, 1 reference |
| host_addr | input | IDX_W (7) | Flat cell address |
| host_wdata | input | 16 | Signed write data |
| host_rdata | output | 16 | Registered read data |
| busy | output | 1 | Engine is walking the matrix |
| done | output | 1 | Last run finished |

## Verification
The assertions assume that `penalty` holds steady while `busy` is high. They also assume that row 0 and column 0 are loaded before `start`, so every neighbour the engine reads already holds a defined value. The stimulus changes the penalty only between runs and loads all cells of both arrays before each run. Inputs are driven on the falling edge. The only stimulus applied during a run is deliberate: an extra `start` and host writes that must be ignored. Expected matrices come from a separate model of the recurrence that uses wrapping 16-bit arithmetic.

// File: rtl/nw_pkg.sv
package nw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WRAP = 2'd2
  } run_state_t;

endpackage

// File: rtl/nw_diag_walker.sv
// Walks (diagonal, step) pairs in ascending order and forms the flat cell index.
module nw_diag_walker #(
  parameter int COLS  = 8,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             advance,
  output logic [IDX_W-1:0] cell_idx,
  output logic             last_cell
);
  localparam int LAST_DIAG = COLS - 4;
  localparam int CNT_W     = $clog2(COLS) + 1;

  logic [CNT_W-1:0] diag_q;
  logic [CNT_W-1:0] step_q;
  logic             diag_end;

  assign diag_end  = (step_q == diag_q);
  assign last_cell = diag_end && (diag_q == CNT_W'(LAST_DIAG));

  always_ff @(posedge clk) begin
    if (rst || go) begin
      diag_q <= '0;
      step_q <= '0;
    end else if (advance && !last_cell) begin
      if (diag_end) begin
        diag_q <= diag_q + CNT_W'(1);
        step_q <= '0;
      end else begin
        step_q <= step_q + CNT_W'(1);
      end
    end
  end

  // (step + 1) * COLS + (diag + 1 - step), kept at the full index width
  assign cell_idx = (IDX_W'(step_q) + IDX_W'(1)) * IDX_W'(COLS)
                  + IDX_W'(diag_q) + IDX_W'(1) - IDX_W'(step_q);

endmodule

// File: rtl/nw_cell_max.sv
// Three-way maximum of the alignment recurrence, wrapping signed arithmetic.
module nw_cell_max #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] up_left,
  input  logic signed [W-1:0] left,
  input  logic signed [W-1:0] up,
  input  logic signed [W-1:0] ref_score,
  input  logic signed [W-1:0] pen,
  output logic signed [W-1:0] best
);
  logic signed [W-1:0] cand_match;
  logic signed [W-1:0] cand_left;
  logic signed [W-1:0] cand_up;
  logic signed [W-1:0] best_lu;

  always_comb begin
    cand_match = up_left + ref_score;
    cand_left  = left - pen;
    cand_up    = up - pen;
    best_lu    = (cand_left > cand_up) ? cand_left : cand_up;
    best       = (cand_match > best_lu) ? cand_match : best_lu;
  end

endmodule

// File: rtl/nw_score_store.sv
// Score matrix and reference array: one write port each, engine reads, registered host read.
module nw_score_store #(
  parameter int DEPTH = 128,
  parameter int W     = 16,
  parameter int AW    = 7
) (
  input  logic                clk,
  input  logic                mat_we,
  input  logic [AW-1:0]       mat_waddr,
  input  logic signed [W-1:0] mat_wdata,
  input  logic                ref_we,
  input  logic [AW-1:0]       ref_waddr,
  input  logic signed [W-1:0] ref_wdata,
  input  logic [AW-1:0]       rd_ul_addr,
  input  logic [AW-1:0]       rd_l_addr,
  input  logic [AW-1:0]       rd_u_addr,
  input  logic [AW-1:0]       rd_ref_addr,
  output logic signed [W-1:0] rd_ul,
  output logic signed [W-1:0] rd_l,
  output logic signed [W-1:0] rd_u,
  output logic signed [W-1:0] rd_ref,
  input  logic                host_sel,
  input  logic [AW-1:0]       host_addr,
  output logic signed [W-1:0] host_rdata
);
  logic signed [W-1:0] mat_mem [DEPTH];
  logic signed [W-1:0] ref_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (mat_we) mat_mem[mat_waddr] <= mat_wdata;
  end

  always_ff @(posedge clk) begin
    if (ref_we) ref_mem[ref_waddr] <= ref_wdata;
  end

  assign rd_ul  = mat_mem[rd_ul_addr];
  assign rd_l   = mat_mem[rd_l_addr];
  assign rd_u   = mat_mem[rd_u_addr];
  assign rd_ref = ref_mem[rd_ref_addr];

  always_ff @(posedge clk) begin
    host_rdata <= host_sel ? ref_mem[host_addr] : mat_mem[host_addr];
  end

endmodule

// File: rtl/nw_scorer.sv
// Top: run control, single engine writer, gated host access.
module nw_scorer #(
  parameter int COLS  = 8,
  parameter int ROWS  = 16,
  parameter int W     = 16,
  parameter int IDX_W = $clog2(COLS * ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic signed [W-1:0] penalty,
  input  logic                host_we,
  input  logic                host_sel,
  input  logic [IDX_W-1:0]    host_addr,
  input  logic signed [W-1:0] host_wdata,
  output logic signed [W-1:0] host_rdata,
  output logic                busy,
  output logic                done
);
  import nw_pkg::*;

  localparam int DEPTH = COLS * ROWS;

  run_state_t          state_q;
  logic                go;
  logic                eng_we;
  logic                last_cell;
  logic [IDX_W-1:0]    eng_idx;
  logic [IDX_W-1:0]    ul_idx, l_idx, u_idx;
  logic signed [W-1:0] v_ul, v_l, v_u, v_ref, v_best;
  logic                host_open;
  logic                mat_we, ref_we;
  logic [IDX_W-1:0]    mat_waddr;
  logic signed [W-1:0] mat_wdata;

  assign go        = start && (state_q == ST_IDLE);
  assign eng_we    = (state_q == ST_RUN);
  assign busy      = (state_q != ST_IDLE);
  assign host_open = host_we && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          done    <= 1'b0;
        end
        ST_RUN:  if (last_cell) state_q <= ST_WRAP;
        ST_WRAP: begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  nw_diag_walker #(.COLS(COLS), .IDX_W(IDX_W)) walker_i (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .advance  (eng_we),
    .cell_idx (eng_idx),
    .last_cell(last_cell)
  );

  assign ul_idx = eng_idx - IDX_W'(COLS) - IDX_W'(1);
  assign l_idx  = eng_idx - IDX_W'(1);
  assign u_idx  = eng_idx - IDX_W'(COLS);

  nw_cell_max #(.W(W)) max_i (
    .up_left  (v_ul),
    .left     (v_l),
    .up       (v_u),
    .ref_score(v_ref),
    .pen      (penalty),
    .best     (v_best)
  );

  assign mat_we    = eng_we || (host_open && !host_sel);
  assign mat_waddr = eng_we ? eng_idx : host_addr;
  assign mat_wdata = eng_we ? v_best : host_wdata;
  assign ref_we    = host_open && host_sel;

  nw_score_store #(.DEPTH(DEPTH), .W(W), .AW(IDX_W)) store_i (
    .clk        (clk),
    .mat_we     (mat_we),
    .mat_waddr  (mat_waddr),
    .mat_wdata  (mat_wdata),
    .ref_we     (ref_we),
    .ref_waddr  (host_addr),
    .ref_wdata  (host_wdata),
    .rd_ul_addr (ul_idx),
    .rd_l_addr  (l_idx),
    .rd_u_addr  (u_idx),
    .rd_ref_addr(eng_idx),
    .rd_ul      (v_ul),
    .rd_l       (v_l),
    .rd_u       (v_u),
    .rd_ref     (v_ref),
    .host_sel   (host_sel),
    .host_addr  (host_addr),
    .host_rdata (host_rdata)
  );

endmodule

// File: rtl/nw_scorer_chk.sv
module nw_scorer_chk #(
  parameter int COLS  = 8,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             eng_we,
  input logic [IDX_W-1:0] eng_idx
);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && !done)); // R1

  AST_WRITE_INTERIOR: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> ((eng_idx >= IDX_W'(COLS)) && ((eng_idx % IDX_W'(COLS)) != '0))); // R5

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> busy); // R6

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy)); // R6

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R6

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done)); // R7

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R7

  AST_START_IN_RUN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && eng_we) |=> busy); // R8

endmodule

bind nw_scorer nw_scorer_chk #(.COLS(COLS), .IDX_W(IDX_W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .eng_we (eng_we),
  .eng_idx(eng_idx)
);

// File: tb/nw_scorer_tb_top.sv
module nw_scorer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COLS  = 8;
  localparam int ROWS  = 16;
  localparam int W     = 16;
  localparam int DEPTH = COLS * ROWS;
  localparam int AW    = $clog2(DEPTH);
  localparam int NCELL = (COLS - 3) * (COLS - 2) / 2;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                start = 1'b0;
  logic signed [W-1:0] penalty = '0;
  logic                host_we = 1'b0;
  logic                host_sel = 1'b0;
  logic [AW-1:0]       host_addr = '0;
  logic signed [W-1:0] host_wdata = '0;
  logic signed [W-1:0] host_rdata;
  logic                busy, done;

  logic signed [W-1:0] mdl_m [DEPTH];
  logic signed [W-1:0] mdl_r [DEPTH];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nw_scorer #(.COLS(COLS), .ROWS(ROWS), .W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .penalty(penalty),
    .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .done(done)
  );

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired: actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hwrite(input bit sel, input int addr, input logic signed [W-1:0] val);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_addr = AW'(addr); host_wdata = val;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input bit sel, input int addr, output logic signed [W-1:0] val);
    @(negedge clk);
    host_sel = sel; host_addr = AW'(addr);
    @(negedge clk);
    val = host_rdata;
  endtask

  task automatic load_all();
    for (int k = 0; k < DEPTH; k++) begin
      hwrite(1'b0, k, mdl_m[k]);
      hwrite(1'b1, k, mdl_r[k]);
    end
  endtask

  // Reference recurrence, ascending diagonals, wrapping 16-bit arithmetic
  task automatic model_run(input logic signed [W-1:0] p);
    for (int d = 0; d <= COLS - 4; d++) begin
      for (int s = 0; s <= d; s++) begin
        int k;
        logic signed [W-1:0] a, b, c, m;
        k = (s + 1) * COLS + (d + 1 - s);
        a = mdl_m[k-1-COLS] + mdl_r[k];
        b = mdl_m[k-1] - p;
        c = mdl_m[k-COLS] - p;
        m = (b > c) ? b : c;
        mdl_m[k] = (a > m) ? a : m;
      end
    end
  endtask

  task automatic run_timed(output int cyc);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic compare_all(input string tag);
    int bad = 0;
    for (int k = 0; k < DEPTH; k++) begin
      logic signed [W-1:0] v;
      hread(1'b0, k, v);
      if (v !== mdl_m[k]) begin
        bad++;
        $display("FAIL R3 %s cell %0d: actual=%0d expected=%0d", tag, k, v, mdl_m[k]);
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic t_reset();
    check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(done === 1'b0, "R1", "done after reset", int'(done), 0);
  endtask

  task automatic t_ramp();
    int cyc;
    penalty = 16'sd2;
    for (int k = 0; k < DEPTH; k++) begin
      mdl_m[k] = ((k < COLS) || (k % COLS == 0)) ? W'(-2 * ((k / COLS) + (k % COLS))) : '0;
      mdl_r[k] = W'((k % 5) - 2);
    end
    load_all();
    model_run(penalty);
    run_timed(cyc);
    check(cyc == NCELL + 1, "R6", "cycles to done", cyc, NCELL + 1);
    compare_all("R2 ramp");
  endtask

  task automatic t_mixed();
    int cyc;
    logic signed [W-1:0] v;
    penalty = -16'sd3;
    for (int k = 0; k < DEPTH; k++) begin
      mdl_m[k] = W'(((k * 97 + 13) % 200) - 100);
      mdl_r[k] = W'(((k * 31 + 7) % 41) - 20);
    end
    load_all();
    model_run(penalty);
    run_timed(cyc);
    check(cyc == NCELL + 1, "R6", "cycles to done (mixed)", cyc, NCELL + 1);
    compare_all("R3 mixed");
    hread(1'b0, 0, v);
    check(v == W'(-87), "R5", "corner cell untouched", int'(v), -87);
    hread(1'b0, (COLS - 3) * COLS + 1, v);
    check(v == mdl_m[(COLS - 3) * COLS + 1], "R2", "last diagonal cell", int'(v),
          int'(mdl_m[(COLS - 3) * COLS + 1]));
  endtask

  task automatic t_wrap();
    int cyc;
    logic signed [W-1:0] v;
    penalty = 16'sd20000;
    for (int k = 0; k < DEPTH; k++) begin
      mdl_m[k] = 16'sd32000;
      mdl_r[k] = 16'sd1000;
    end
    load_all();
    model_run(penalty);
    run_timed(cyc);
    hread(1'b0, COLS + 1, v);
    check(v == 16'sd12000, "R4", "wrapped diagonal loses", int'(v), 12000);
    compare_all("R4 wrap");
  endtask

  task automatic t_done_hold();
    check(done === 1'b1, "R7", "done before hold", int'(done), 1);
    repeat (5) @(negedge clk);
    check(done === 1'b1, "R7", "done held while idle", int'(done), 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b0, "R7", "done cleared by start", int'(done), 0);
    check(busy === 1'b1, "R7", "busy after start", int'(busy), 1);
    repeat (NCELL + 3) @(negedge clk);
    check(done === 1'b1, "R7", "done after rerun", int'(done), 1);
  endtask

  task automatic t_busy_ignore();
    int cyc;
    logic signed [W-1:0] v;
    penalty = 16'sd1;
    for (int k = 0; k < DEPTH; k++) begin
      mdl_m[k] = W'((k * 7) % 23);
      mdl_r[k] = W'((k % 3) - 1);
    end
    load_all();
    model_run(penalty);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    repeat (3) begin @(negedge clk); cyc++; end
    start = 1'b1;
    host_we = 1'b1; host_sel = 1'b0; host_addr = AW'(DEPTH - 1); host_wdata = 16'sd999;
    @(negedge clk); cyc++;
    start = 1'b0;
    host_sel = 1'b1; host_addr = AW'((COLS - 3) * COLS + 1); host_wdata = 16'sd5000;
    @(negedge clk); cyc++;
    host_we = 1'b0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == NCELL + 1, "R8", "timing with extra start", cyc, NCELL + 1);
    hread(1'b0, DEPTH - 1, v);
    check(v == mdl_m[DEPTH - 1], "R9", "matrix write while busy dropped", int'(v),
          int'(mdl_m[DEPTH - 1]));
    hread(1'b1, (COLS - 3) * COLS + 1, v);
    check(v == mdl_r[(COLS - 3) * COLS + 1], "R9", "ref write while busy dropped",
          int'(v), int'(mdl_r[(COLS - 3) * COLS + 1]));
    compare_all("R8 busy start");
  endtask

  task automatic t_host_rw();
    logic signed [W-1:0] v;
    hwrite(1'b1, 5, -16'sd1234);
    hwrite(1'b0, 5, 16'sd4321);
    hread(1'b1, 5, v);
    check(v == -16'sd1234, "R9", "reference readback", int'(v), -1234);
    hread(1'b0, 5, v);
    check(v == 16'sd4321, "R9", "matrix readback", int'(v), 4321);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_host_rw();
    t_ramp();
    t_mixed();
    t_wrap();
    t_done_hold();
    t_busy_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule